// File: doc/BRIEF.md
# Transceiver Enable and Status Controller

This block sits between a mode controller and a bus transceiver. It decides when the transceiver may leave its idle state and reports readiness to the host through a clear-to-send output. It also guards the transmit-data input against a stuck-dominant fault, latches bus wake-ups while the system is in standby, and picks the bus bias level from a silence timer.

A Normal entry starts a startup timer. The transceiver becomes active only after that timer has expired and the transmit input is recessive (HIGH). Clear-to-send is withdrawn as soon as the transmit input has been dominant (LOW) for too long, or when the regulator reports undervoltage. In standby, a wake detect pulls the receive-line override active until Normal is entered again. In standby, the bias output drops to ground level once the bus has been quiet for the silence timeout, and returns to mid-supply on the next activity.

Three parameters set the cycle counts: `DOM_TO` (dominant timeout), `START_DLY` (startup delay) and `SIL_TO` (silence timeout).

Top module: `txg_top`

## Requirements
- R1: `cts_o` is HIGH only while `xcvr_en_o` is HIGH, the dominant fault is clear and `uv_i` is LOW.
- R2: After `mode_normal_i` rises with `txd_i` HIGH, `cts_o` stays LOW for `START_DLY` clock edges and goes HIGH on edge `START_DLY+1`. The delay restarts on every Normal entry.
- R3: When `txd_i` is sampled LOW on `DOM_TO` consecutive edges, `cts_o` drops right after the last of them. It returns HIGH on the second edge after `txd_i` goes HIGH again.
- R4: `cts_o` goes LOW combinationally while `uv_i` is HIGH. It returns HIGH one edge after `uv_i` falls, provided the block is still in Normal.
- R5: The transceiver is not activated while `txd_i` is LOW. Once the startup delay has passed, it activates on the first edge at which `txd_i` is HIGH.
- R6: In standby (`mode_normal_i` = 0), a `wake_det_i` pulse sets `rxd_force_low_o` from the next edge on, and it stays set while the block remains in standby. Entering Normal clears it at once. `wake_det_i` has no effect while in Normal.
- R7: In standby, `bias_mid_o` is 0 (ground bias) after `bus_active_i` has been LOW for `SIL_TO` consecutive edges. It is 1 from the edge after `bus_active_i` is seen HIGH. In Normal it is always 1.
- R8: After reset, with `mode_normal_i` LOW, `xcvr_en_o`, `cts_o`, `rxd_force_low_o` and `bias_mid_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_normal_i | input | 1 | 1 = Normal, 0 = Standby |
| txd_i | input | 1 | Transmit data from the host, LOW = dominant |
| bus_active_i | input | 1 | Bus activity indication |
| uv_i | input | 1 | Regulator output undervoltage |
| wake_det_i | input | 1 | Bus wake-up detected |
| xcvr_en_o | output | 1 | Transceiver active enable |
| cts_o | output | 1 | Clear-to-send status to the host |
| rxd_force_low_o | output | 1 | Force the receive line LOW (wake indication) |
| bias_mid_o | output | 1 | 1 = bias at mid-supply, 0 = bias to ground |

## Verification
A timer that is off by one shows up as `cts_o` or `bias_mid_o` changing one edge early or late. The bench therefore samples exactly at the computed edge and at the edge before it. A fault latch that does not clear leaves `cts_o` LOW after `txd_i` returns HIGH. This is visible two edges later. A wake latch that does not clear, or that sets in Normal, appears on `rxd_force_low_o` in the same cycle as the mode change or one edge after the pulse.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int unsigned DEF_DOM_TO    = 8;
  localparam int unsigned DEF_START_DLY = 4;
  localparam int unsigned DEF_SIL_TO    = 10;
endpackage

// File: rtl/txg_run_cnt.sv
// Saturating run-length counter: counts edges while run_i, clears otherwise.
module txg_run_cnt #(
  parameter int unsigned LIMIT    = 8,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= RST_FULL ? LIM_V : '0;
    else if (!run_i)   cnt_q <= '0;
    else if (cnt_q != LIM_V) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM_V);

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM_V);
  p_cnt_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !done_o);
endmodule

// File: rtl/txg_xcvr_ctrl.sv
module txg_xcvr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_normal_i,
  input  logic ready_i,
  input  logic dom_fault_i,
  input  logic uv_i,
  input  logic txd_i,
  output logic active_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else active_q <= mode_normal_i && ready_i && !uv_i && !dom_fault_i
                     && (active_q || txd_i);
  end

  assign active_o = active_q;

  // entry only with recessive transmit input
  p_entry_txd_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && mode_normal_i && !txd_i) |=> !active_q);
  p_leave_standby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_normal_i |=> !active_q);
endmodule

// File: rtl/txg_stby_mon.sv
module txg_stby_mon #(
  parameter int unsigned SIL_TO = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_normal_i,
  input  logic bus_active_i,
  input  logic wake_det_i,
  output logic rxd_force_low_o,
  output logic bias_mid_o
);
  logic wake_q;
  logic silent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            wake_q <= 1'b0;
    else if (mode_normal_i) wake_q <= 1'b0;
    else if (wake_det_i)    wake_q <= 1'b1;
  end

  txg_run_cnt #(.LIMIT(SIL_TO), .RST_FULL(1'b1)) u_sil (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!bus_active_i),
    .done_o (silent)
  );

  assign rxd_force_low_o = wake_q && !mode_normal_i;
  assign bias_mid_o      = mode_normal_i || !silent;

  p_wake_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_normal_i && wake_det_i) |=> (rxd_force_low_o || mode_normal_i));
  p_bias_normal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_normal_i |-> bias_mid_o);
  p_bias_act_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_active_i |=> bias_mid_o);
endmodule

// File: rtl/txg_top.sv
module txg_top
  import txg_pkg::*;
#(
  parameter int unsigned DOM_TO    = DEF_DOM_TO,
  parameter int unsigned START_DLY = DEF_START_DLY,
  parameter int unsigned SIL_TO    = DEF_SIL_TO
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_normal_i,
  input  logic txd_i,
  input  logic bus_active_i,
  input  logic uv_i,
  input  logic wake_det_i,
  output logic xcvr_en_o,
  output logic cts_o,
  output logic rxd_force_low_o,
  output logic bias_mid_o
);
  logic dom_fault;
  logic ready;
  logic active;

  // fault latch: set after DOM_TO low edges, cleared on first high edge
  txg_run_cnt #(.LIMIT(DOM_TO), .RST_FULL(1'b0)) u_dom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (!txd_i),
    .done_o (dom_fault)
  );

  // startup timer restarts on each Normal entry
  txg_run_cnt #(.LIMIT(START_DLY), .RST_FULL(1'b0)) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (mode_normal_i),
    .done_o (ready)
  );

  txg_xcvr_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_normal_i (mode_normal_i),
    .ready_i       (ready),
    .dom_fault_i   (dom_fault),
    .uv_i          (uv_i),
    .txd_i         (txd_i),
    .active_o      (active)
  );

  txg_stby_mon #(.SIL_TO(SIL_TO)) u_stby (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mode_normal_i   (mode_normal_i),
    .bus_active_i    (bus_active_i),
    .wake_det_i      (wake_det_i),
    .rxd_force_low_o (rxd_force_low_o),
    .bias_mid_o      (bias_mid_o)
  );

  assign xcvr_en_o = active;
  assign cts_o     = active && !dom_fault && !uv_i;

  p_cts_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_o |-> xcvr_en_o);
  p_uv_cts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !cts_o);
  p_entry_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_normal_i) |-> !cts_o);
  p_dom_cts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_fault |-> !cts_o);
endmodule

// File: tb/sim_txg_top.sv
`timescale 1ns/1ps
module sim_txg_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DOM_TO = 8, START_DLY = 4, SIL_TO = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_normal, txd, bus_act, uv, wake;
  logic xcvr_en, cts, rxd_fl, bias_mid;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txg_top #(.DOM_TO(DOM_TO), .START_DLY(START_DLY), .SIL_TO(SIL_TO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_normal_i(mode_normal), .txd_i(txd),
    .bus_active_i(bus_act), .uv_i(uv), .wake_det_i(wake),
    .xcvr_en_o(xcvr_en), .cts_o(cts), .rxd_force_low_o(rxd_fl), .bias_mid_o(bias_mid));

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // step n edges, leave at the following negedge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    mode_normal = 0; txd = 1; bus_act = 0; uv = 0; wake = 0;
    rst_ni = 0; step(2);
    chk(xcvr_en, 0, "R8 en"); chk(cts, 0, "R8 cts");
    chk(rxd_fl, 0, "R8 rxd"); chk(bias_mid, 0, "R8 bias");
    rst_ni = 1; step(1);
  endtask

  task automatic t_startup;
    mode_normal = 1; txd = 1;
    step(START_DLY);
    chk(cts, 0, "R2 before delay");
    step(1);
    chk(cts, 1, "R2 after delay");
    chk(xcvr_en, 1, "R1 enable with cts");
    mode_normal = 0; step(1);
    chk(cts, 0, "R2 standby drops cts");
    mode_normal = 1; step(START_DLY);
    chk(cts, 0, "R2 restart before delay");
    step(1);
    chk(cts, 1, "R2 restart after delay");
  endtask

  task automatic t_dominant;
    txd = 0;
    step(DOM_TO - 1);
    chk(cts, 1, "R3 before timeout");
    step(1);
    chk(cts, 0, "R3 timeout");
    chk(xcvr_en, 1, "R1 cts low while en high");
    step(1);
    chk(xcvr_en, 0, "R3 enable dropped");
    txd = 1; step(1);
    chk(cts, 0, "R3 one edge after release");
    step(1);
    chk(cts, 1, "R3 recovered");
  endtask

  task automatic t_uv;
    uv = 1; #1;
    chk(cts, 0, "R4 immediate");
    step(2);
    chk(cts, 0, "R4 held");
    uv = 0; step(1);
    chk(cts, 1, "R4 recovered");
  endtask

  task automatic t_entry_blocked;
    mode_normal = 0; step(1);
    mode_normal = 1; txd = 0;
    step(START_DLY + 2);
    chk(xcvr_en, 0, "R5 blocked while txd low");
    chk(cts, 0, "R5 cts low");
    txd = 1; step(1);
    chk(xcvr_en, 1, "R5 enters on txd high");
    chk(cts, 1, "R5 cts high");
  endtask

  task automatic t_wake;
    mode_normal = 0; step(1);
    chk(rxd_fl, 0, "R6 no wake yet");
    wake = 1; step(1); wake = 0;
    chk(rxd_fl, 1, "R6 wake set");
    step(3);
    chk(rxd_fl, 1, "R6 wake held");
    mode_normal = 1; #1;
    chk(rxd_fl, 0, "R6 cleared on normal");
    wake = 1; step(1); wake = 0; step(1);
    chk(rxd_fl, 0, "R6 ignored in normal");
    mode_normal = 0; #1;
    chk(rxd_fl, 0, "R6 no stale wake");
  endtask

  task automatic t_bias;
    mode_normal = 1; bus_act = 0; #1;
    chk(bias_mid, 1, "R7 normal mid");
    mode_normal = 0; bus_act = 1; step(1);
    chk(bias_mid, 1, "R7 activity mid");
    bus_act = 0;
    step(SIL_TO - 1);
    chk(bias_mid, 1, "R7 before silence timeout");
    step(1);
    chk(bias_mid, 0, "R7 silence to ground");
    bus_act = 1; step(1);
    chk(bias_mid, 1, "R7 back to mid");
    bus_act = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_startup();
    t_dominant();
    t_uv();
    t_entry_blocked();
    t_wake();
    t_bias();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule